// File: doc/BRIEF.md
# Embedded flash command controller

This block sits between a register bus and an on-chip flash array. Software sees four word registers: mode, command, status and result. It issues an operation by writing a command word that carries a guard byte, an operation code and a page argument. When the word is valid, the controller drops its ready flag for a fixed number of clock cycles. It then applies the operation and reports any failure in the status register.

A behavioural register array stands in for the flash cells. Data is first loaded into a page buffer through a separate write port. An erase-and-write operation then copies the whole buffer over one page. Lock bits guard fixed groups of pages called regions. Two operations return data through the result register: the geometry descriptor and the lock bits. For these, each read of the result register moves on to the next word.

All addresses below are register indices: 0 is mode, 1 is command, 2 is status and 3 is result. A read has side effects only when `reg_re_i` is high. The read data follows `reg_addr_i` combinationally.

Top module: `flash_ctl`

## Requirements
- R1: A command write is taken only when bits 31:24 hold 0x5A. With any other value, ready stays 1, the array and lock bits are untouched, and status bit 1 (command error) is set.
- R2: The code in bits 7:0 selects the operation: 0x00 descriptor, 0x03 erase-and-write, 0x08 set lock, 0x09 clear lock, 0x0A read locks. Any other code (0x01, 0x02, 0x04 and 0x05 included) has no effect, leaves ready at 1 and sets status bit 1.
- R3: An accepted command holds status bit 0 (ready) at 0 for exactly BUSY_CYCLES cycles, starting the cycle after the write. Its effect is applied when ready returns to 1.
- R4: A command written while ready is 0 is dropped and sets status bit 1. The command in progress still completes.
- R5: A status read with `reg_re_i` returns the error bits and then clears bit 1 and bit 2. An accepted command also clears them.
- R6: After a descriptor command, successive result reads return these words in turn: id, total bytes, page bytes, plane count (1), plane bytes, region count, and then one byte-size word per region. Reads past the last word return 0.
- R7: After a read-locks command, result word w holds the lock bits of regions 32w to 32w+31. Region i sits at bit i mod 32, and page p belongs to region p / PAGES_PER_REGION.
- R8: Set-lock and clear-lock (argument in bits 23:8) change only the lock bit of the region that holds the given page.
- R9: Erase-and-write replaces all words of the page with the page buffer. After the write the buffer returns to all ones, so buffer words not loaded before the next write land as 0xFFFFFFFF.
- R10: Erase-and-write to a page in a locked region leaves the array unchanged and sets status bit 2 (lock error).
- R11: A page argument at or above the page count makes erase-and-write, set-lock and clear-lock raise status bit 1 with no effect.
- R12: After reset the following hold: ready is 1, both error bits are 0, the array is all ones, no region is locked, mode is 0, and the result register reads 0.
- R13: The mode register reads back the last word written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (enables read side effects) |
| reg_addr_i | input | 2 | Register index: 0 mode, 1 command, 2 status, 3 result |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| buf_we_i | input | 1 | Page buffer write strobe |
| buf_idx_i | input | $clog2(PAGE_WORDS) | Word index in the page buffer |
| buf_wdata_i | input | 32 | Page buffer write data |
| arr_addr_i | input | $clog2(total words) | Array word address for reads |
| arr_rdata_o | output | 32 | Array word at `arr_addr_i` |

## Verification
The assertions check on every cycle the rules that concern a single step. These are: a bad guard byte or unknown code never starts a busy period, a write during busy always flags an error, ready cannot return early, a status read clears the error flag, a locked erase-and-write leaves the array still, a lock operation flips at most one bit, and the result pointer advances on each read. Other behaviour can only be shown by the bench's scenarios. This covers the exact length of the busy window, the content and order of the descriptor words, the lock-bit layout seen from the result register, and the absence of merging when a page is rewritten from a partly loaded buffer.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam logic [7:0] CMD_KEY = 8'h5A;

  typedef enum logic [7:0] {
    OP_DESC = 8'h00,
    OP_EWP  = 8'h03,
    OP_SET  = 8'h08,
    OP_CLR  = 8'h09,
    OP_GLB  = 8'h0A
  } op_e;

  typedef enum logic [1:0] {RES_NONE, RES_DESC, RES_LOCK} res_e;

  localparam int ST_READY   = 0;
  localparam int ST_CMDERR  = 1;
  localparam int ST_LOCKERR = 2;
endpackage

// File: rtl/flash_ctl_seq.sv
module flash_ctl_seq
  import flash_ctl_pkg::*;
#(
  parameter int N_PAGES     = 32,
  parameter int BUSY_CYCLES = 5,
  localparam int PAGE_AW    = $clog2(N_PAGES),
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_we_i,
  input  logic [31:0]        cmd_word_i,
  input  logic               status_rd_i,
  input  logic               locked_i,
  output logic               busy_o,
  output logic               done_o,
  output op_e                op_o,
  output logic [PAGE_AW-1:0] page_o,
  output logic               cmd_err_o,
  output logic               lock_err_o
);
  logic             busy_q, cmd_err_q, lock_err_q;
  logic [CNT_W-1:0] cnt_q;
  op_e              op_q;
  logic [PAGE_AW-1:0] page_q;

  logic [7:0]  key, code;
  logic [15:0] arg;
  logic        code_ok, needs_page, arg_ok, accept;

  assign key  = cmd_word_i[31:24];
  assign arg  = cmd_word_i[23:8];
  assign code = cmd_word_i[7:0];

  always_comb begin
    code_ok    = 1'b0;
    needs_page = 1'b0;
    case (code)
      OP_DESC, OP_GLB:        code_ok = 1'b1;
      OP_EWP, OP_SET, OP_CLR: begin code_ok = 1'b1; needs_page = 1'b1; end
      default: ;
    endcase
  end

  assign arg_ok = !needs_page || ({16'd0, arg} < 32'(N_PAGES));
  assign accept = !busy_q && (key == CMD_KEY) && code_ok && arg_ok;
  assign done_o = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      op_q       <= OP_DESC;
      page_q     <= '0;
      cmd_err_q  <= 1'b0;
      lock_err_q <= 1'b0;
    end else begin
      if (status_rd_i) begin
        cmd_err_q  <= 1'b0;
        lock_err_q <= 1'b0;
      end
      if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (done_o) begin
          busy_q <= 1'b0;
          if (op_q == OP_EWP && locked_i) lock_err_q <= 1'b1;
        end
      end
      if (cmd_we_i) begin
        if (accept) begin
          busy_q     <= 1'b1;
          cnt_q      <= CNT_W'(BUSY_CYCLES);
          op_q       <= op_e'(code);
          page_q     <= arg[PAGE_AW-1:0];
          cmd_err_q  <= 1'b0;
          lock_err_q <= 1'b0;
        end else begin
          cmd_err_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign op_o       = op_q;
  assign page_o     = page_q;
  assign cmd_err_o  = cmd_err_q;
  assign lock_err_o = lock_err_q;

  AST_BAD_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !busy_q && key != CMD_KEY) |=> (!busy_q && cmd_err_q)); // R1
  AST_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !busy_q && !code_ok) |=> (!busy_q && cmd_err_q)); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != CNT_W'(1)) |=> busy_q); // R3
  AST_BUSY_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_we_i) |=> cmd_err_q); // R4
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !cmd_we_i) |=> !cmd_err_q); // R5
  AST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !busy_q && needs_page && !arg_ok) |=> !busy_q); // R11
endmodule

// File: rtl/flash_ctl_store.sv
module flash_ctl_store
  import flash_ctl_pkg::*;
#(
  parameter int PAGE_WORDS       = 4,
  parameter int PAGES_PER_REGION = 4,
  parameter int N_REGIONS        = 8,
  localparam int N_PAGES = PAGES_PER_REGION * N_REGIONS,
  localparam int N_WORDS = N_PAGES * PAGE_WORDS,
  localparam int PAGE_AW = $clog2(N_PAGES),
  localparam int ARR_AW  = $clog2(N_WORDS),
  localparam int BUF_AW  = $clog2(PAGE_WORDS),
  localparam int REG_AW  = $clog2(N_REGIONS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 done_i,
  input  op_e                  op_i,
  input  logic [PAGE_AW-1:0]   page_i,
  input  logic                 buf_we_i,
  input  logic [BUF_AW-1:0]    buf_idx_i,
  input  logic [31:0]          buf_wdata_i,
  input  logic [ARR_AW-1:0]    arr_addr_i,
  output logic [31:0]          arr_rdata_o,
  output logic                 locked_o,
  output logic [N_REGIONS-1:0] lock_o
);
  logic [N_WORDS-1:0][31:0]    mem_q;
  logic [PAGE_WORDS-1:0][31:0] buf_q;
  logic [N_REGIONS-1:0]        lock_q;
  logic [REG_AW-1:0]           region;
  logic                        do_write, do_set, do_clr;

  assign region   = REG_AW'(int'(page_i) / PAGES_PER_REGION);
  assign locked_o = lock_q[region];
  assign do_write = done_i && op_i == OP_EWP && !locked_o;
  assign do_set   = done_i && op_i == OP_SET;
  assign do_clr   = done_i && op_i == OP_CLR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '1;
      buf_q  <= '1;
      lock_q <= '0;
    end else begin
      if (buf_we_i) buf_q[buf_idx_i] <= buf_wdata_i;
      if (do_write) begin
        for (int w = 0; w < PAGE_WORDS; w++)
          mem_q[ARR_AW'(int'(page_i) * PAGE_WORDS + w)] <= buf_q[w];
        buf_q <= '1; // whole-page replace, buffer back to erased
      end
      if (do_set) lock_q[region] <= 1'b1;
      if (do_clr) lock_q[region] <= 1'b0;
    end
  end

  assign arr_rdata_o = mem_q[arr_addr_i];
  assign lock_o      = lock_q;

  AST_LOCKED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && op_i == OP_EWP && locked_o) |=> $stable(mem_q)); // R10
  AST_ONE_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (op_i == OP_SET || op_i == OP_CLR)) |=> ($countones(lock_q ^ $past(lock_q)) <= 1)); // R8
  AST_LOCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && (op_i == OP_SET || op_i == OP_CLR)) |=> $stable(lock_q)); // R8
endmodule

// File: rtl/flash_ctl_result.sv
module flash_ctl_result
  import flash_ctl_pkg::*;
#(
  parameter int          PAGE_WORDS       = 4,
  parameter int          PAGES_PER_REGION = 4,
  parameter int          N_REGIONS        = 8,
  parameter logic [31:0] FLASH_ID         = 32'h1234_0001,
  localparam int REGION_BYTES = PAGES_PER_REGION * PAGE_WORDS * 4,
  localparam int TOTAL_BYTES  = REGION_BYTES * N_REGIONS,
  localparam int LOCK_WORDS   = (N_REGIONS + 31) / 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 done_i,
  input  op_e                  op_i,
  input  logic                 rd_i,
  input  logic [N_REGIONS-1:0] lock_i,
  output logic [31:0]          data_o
);
  res_e       mode_q;
  logic [7:0] idx_q;
  logic [LOCK_WORDS*32-1:0] lock_pad;
  logic [31:0] desc_word, lock_word;
  int          ix;

  assign lock_pad = (LOCK_WORDS*32)'(lock_i);
  assign ix       = int'(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RES_NONE;
      idx_q  <= '0;
    end else if (done_i && (op_i == OP_DESC || op_i == OP_GLB)) begin
      mode_q <= (op_i == OP_DESC) ? RES_DESC : RES_LOCK;
      idx_q  <= '0;
    end else if (rd_i && idx_q != '1) begin
      idx_q  <= idx_q + 8'd1;
    end
  end

  always_comb begin
    desc_word = '0;
    if      (ix == 0) desc_word = FLASH_ID;
    else if (ix == 1) desc_word = 32'(TOTAL_BYTES);
    else if (ix == 2) desc_word = 32'(PAGE_WORDS * 4);
    else if (ix == 3) desc_word = 32'd1;
    else if (ix == 4) desc_word = 32'(TOTAL_BYTES);
    else if (ix == 5) desc_word = 32'(N_REGIONS);
    else if (ix < 6 + N_REGIONS) desc_word = 32'(REGION_BYTES);
  end

  always_comb begin
    lock_word = '0;
    for (int w = 0; w < LOCK_WORDS; w++)
      if (ix == w) lock_word = lock_pad[w*32 +: 32];
  end

  always_comb begin
    case (mode_q)
      RES_DESC: data_o = desc_word;
      RES_LOCK: data_o = lock_word;
      default:  data_o = '0;
    endcase
  end

  AST_RES_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i && idx_q != '1) |=> (idx_q == $past(idx_q) + 8'd1)); // R6
endmodule

// File: rtl/flash_ctl.sv
module flash_ctl
  import flash_ctl_pkg::*;
#(
  parameter int          PAGE_WORDS       = 4,
  parameter int          PAGES_PER_REGION = 4,
  parameter int          N_REGIONS        = 8,
  parameter int          BUSY_CYCLES      = 5,
  parameter logic [31:0] FLASH_ID         = 32'h1234_0001
) (
  input  logic                                                   clk_i,
  input  logic                                                   rst_ni,
  input  logic                                                   reg_we_i,
  input  logic                                                   reg_re_i,
  input  logic [1:0]                                             reg_addr_i,
  input  logic [31:0]                                            reg_wdata_i,
  output logic [31:0]                                            reg_rdata_o,
  input  logic                                                   buf_we_i,
  input  logic [$clog2(PAGE_WORDS)-1:0]                          buf_idx_i,
  input  logic [31:0]                                            buf_wdata_i,
  input  logic [$clog2(PAGE_WORDS*PAGES_PER_REGION*N_REGIONS)-1:0] arr_addr_i,
  output logic [31:0]                                            arr_rdata_o
);
  localparam int N_PAGES = PAGES_PER_REGION * N_REGIONS;
  localparam int PAGE_AW = $clog2(N_PAGES);

  logic [31:0]          mode_q, status_w, result_w;
  logic                 cmd_we, status_rd, res_rd;
  logic                 busy, done, locked, cmd_err, lock_err;
  op_e                  op;
  logic [PAGE_AW-1:0]   page;
  logic [N_REGIONS-1:0] locks;

  assign cmd_we    = reg_we_i && reg_addr_i == 2'd1;
  assign status_rd = reg_re_i && reg_addr_i == 2'd2;
  assign res_rd    = reg_re_i && reg_addr_i == 2'd3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             mode_q <= '0;
    else if (reg_we_i && reg_addr_i == 2'd0) mode_q <= reg_wdata_i;
  end

  flash_ctl_seq #(.N_PAGES(N_PAGES), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk_i, .rst_ni,
    .cmd_we_i(cmd_we), .cmd_word_i(reg_wdata_i), .status_rd_i(status_rd),
    .locked_i(locked), .busy_o(busy), .done_o(done), .op_o(op), .page_o(page),
    .cmd_err_o(cmd_err), .lock_err_o(lock_err)
  );

  flash_ctl_store #(.PAGE_WORDS(PAGE_WORDS), .PAGES_PER_REGION(PAGES_PER_REGION),
                    .N_REGIONS(N_REGIONS)) u_store (
    .clk_i, .rst_ni,
    .done_i(done), .op_i(op), .page_i(page),
    .buf_we_i, .buf_idx_i, .buf_wdata_i,
    .arr_addr_i, .arr_rdata_o,
    .locked_o(locked), .lock_o(locks)
  );

  flash_ctl_result #(.PAGE_WORDS(PAGE_WORDS), .PAGES_PER_REGION(PAGES_PER_REGION),
                     .N_REGIONS(N_REGIONS), .FLASH_ID(FLASH_ID)) u_result (
    .clk_i, .rst_ni,
    .done_i(done), .op_i(op), .rd_i(res_rd), .lock_i(locks), .data_o(result_w)
  );

  always_comb begin
    status_w             = '0;
    status_w[ST_READY]   = !busy;
    status_w[ST_CMDERR]  = cmd_err;
    status_w[ST_LOCKERR] = lock_err;
  end

  always_comb begin
    case (reg_addr_i)
      2'd0:    reg_rdata_o = mode_q;
      2'd2:    reg_rdata_o = status_w;
      2'd3:    reg_rdata_o = result_w;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: tb/sim_flash_ctl.sv
`timescale 1ns/1ps
module sim_flash_ctl;
  localparam int PW = 4, PPR = 4, NREG = 8, BUSY = 5;
  localparam logic [31:0] ID = 32'h1234_0001;

  localparam logic [2:0] K_W = 3'd0, K_R = 3'd1, K_B = 3'd2, K_A = 3'd3, K_D = 3'd4;
  typedef struct packed {
    logic [2:0]  k;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  function automatic logic [31:0] cw(input logic [15:0] pg, input logic [7:0] code);
    return {8'h5A, pg, code};
  endfunction

  localparam int N_VEC = 64;
  localparam vec_t TBL [N_VEC] = '{
    // descriptor words, R6
    '{K_W, 8'd1, cw(0, 8'h00), 32'd0, 4'd6}, '{K_D, 8'd0, 32'd0, 32'd0, 4'd6},
    '{K_R, 8'd3, 32'd0, ID, 4'd6},           '{K_R, 8'd3, 32'd0, 32'd512, 4'd6},
    '{K_R, 8'd3, 32'd0, 32'd16, 4'd6},       '{K_R, 8'd3, 32'd0, 32'd1, 4'd6},
    '{K_R, 8'd3, 32'd0, 32'd512, 4'd6},      '{K_R, 8'd3, 32'd0, 32'd8, 4'd6},
    '{K_R, 8'd3, 32'd0, 32'd64, 4'd6},       '{K_R, 8'd3, 32'd0, 32'd64, 4'd6},
    // full page write, R9
    '{K_B, 8'd0, 32'hA0, 32'd0, 4'd9}, '{K_B, 8'd1, 32'hA1, 32'd0, 4'd9},
    '{K_B, 8'd2, 32'hA2, 32'd0, 4'd9}, '{K_B, 8'd3, 32'hA3, 32'd0, 4'd9},
    '{K_W, 8'd1, cw(5, 8'h03), 32'd0, 4'd9}, '{K_D, 8'd0, 32'd0, 32'd0, 4'd9},
    '{K_A, 8'd20, 32'd0, 32'hA0, 4'd9}, '{K_A, 8'd23, 32'd0, 32'hA3, 4'd9},
    '{K_A, 8'd24, 32'd0, 32'hFFFF_FFFF, 4'd9},
    // partial buffer does not merge, R9
    '{K_B, 8'd1, 32'hB1, 32'd0, 4'd9}, '{K_W, 8'd1, cw(5, 8'h03), 32'd0, 4'd9},
    '{K_D, 8'd0, 32'd0, 32'd0, 4'd9},
    '{K_A, 8'd20, 32'd0, 32'hFFFF_FFFF, 4'd9}, '{K_A, 8'd21, 32'd0, 32'hB1, 4'd9},
    // lock region 2 via page 9, R7 R8
    '{K_W, 8'd1, cw(9, 8'h08), 32'd0, 4'd8}, '{K_D, 8'd0, 32'd0, 32'd0, 4'd8},
    '{K_W, 8'd1, cw(0, 8'h0A), 32'd0, 4'd7}, '{K_D, 8'd0, 32'd0, 32'd0, 4'd7},
    '{K_R, 8'd3, 32'd0, 32'h4, 4'd7},        '{K_R, 8'd3, 32'd0, 32'h0, 4'd7},
    // lock region 7 via page 31, R8
    '{K_W, 8'd1, cw(31, 8'h08), 32'd0, 4'd8}, '{K_D, 8'd0, 32'd0, 32'd0, 4'd8},
    '{K_W, 8'd1, cw(0, 8'h0A), 32'd0, 4'd8},  '{K_D, 8'd0, 32'd0, 32'd0, 4'd8},
    '{K_R, 8'd3, 32'd0, 32'h84, 4'd8},
    // clear region 2 via page 8, R8
    '{K_W, 8'd1, cw(8, 8'h09), 32'd0, 4'd8}, '{K_D, 8'd0, 32'd0, 32'd0, 4'd8},
    '{K_W, 8'd1, cw(0, 8'h0A), 32'd0, 4'd8}, '{K_D, 8'd0, 32'd0, 32'd0, 4'd8},
    '{K_R, 8'd3, 32'd0, 32'h80, 4'd8},
    // write into locked region 7, R10 then R5
    '{K_B, 8'd0, 32'hC0, 32'd0, 4'd10}, '{K_W, 8'd1, cw(28, 8'h03), 32'd0, 4'd10},
    '{K_D, 8'd0, 32'd0, 32'd0, 4'd10},  '{K_R, 8'd2, 32'd0, 32'd5, 4'd10},
    '{K_R, 8'd2, 32'd0, 32'd1, 4'd5},   '{K_A, 8'd112, 32'd0, 32'hFFFF_FFFF, 4'd10},
    // unsupported codes, R2
    '{K_W, 8'd1, cw(0, 8'h05), 32'd0, 4'd2}, '{K_R, 8'd2, 32'd0, 32'd3, 4'd2},
    '{K_R, 8'd2, 32'd0, 32'd1, 4'd2},        '{K_W, 8'd1, cw(2, 8'h01), 32'd0, 4'd2},
    '{K_R, 8'd2, 32'd0, 32'd3, 4'd2},        '{K_R, 8'd2, 32'd0, 32'd1, 4'd2},
    // wrong key, R1
    '{K_W, 8'd1, {8'h5B, 16'd6, 8'h03}, 32'd0, 4'd1}, '{K_R, 8'd2, 32'd0, 32'd3, 4'd1},
    '{K_A, 8'd24, 32'd0, 32'hFFFF_FFFF, 4'd1},
    // page out of range, R11
    '{K_W, 8'd1, cw(32, 8'h03), 32'd0, 4'd11}, '{K_R, 8'd2, 32'd0, 32'd3, 4'd11},
    '{K_R, 8'd2, 32'd0, 32'd1, 4'd11},
    // mode register, R13
    '{K_W, 8'd0, 32'h0000_0300, 32'd0, 4'd13}, '{K_R, 8'd0, 32'd0, 32'h0000_0300, 4'd13},
    // accepted command clears errors, R5
    '{K_W, 8'd1, 32'h0000_0000, 32'd0, 4'd5}, '{K_W, 8'd1, cw(0, 8'h0A), 32'd0, 4'd5},
    '{K_D, 8'd0, 32'd0, 32'd0, 4'd5},         '{K_R, 8'd2, 32'd0, 32'd1, 4'd5}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0, buf_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, buf_wdata = '0;
  logic [1:0]  buf_idx = '0;
  logic [6:0]  arr_addr = '0;
  logic [31:0] reg_rdata, arr_rdata;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  flash_ctl #(.PAGE_WORDS(PW), .PAGES_PER_REGION(PPR), .N_REGIONS(NREG),
              .BUSY_CYCLES(BUSY), .FLASH_ID(ID)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .buf_we_i(buf_we), .buf_idx_i(buf_idx), .buf_wdata_i(buf_wdata),
    .arr_addr_i(arr_addr), .arr_rdata_o(arr_rdata)
  );

  task automatic check(input int r, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_re = 1'b0;
  endtask

  task automatic reg_peek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic buf_write(input logic [1:0] i, input logic [31:0] d);
    @(negedge clk);
    buf_idx = i; buf_wdata = d; buf_we = 1'b1;
    @(posedge clk); #1;
    buf_we = 1'b0;
  endtask

  task automatic arr_peek(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    arr_addr = a;
    #1 d = arr_rdata;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] got;
    int low;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 reset state
    reg_peek(2'd2, got); check(12, got, 32'd1, "status after reset");
    reg_peek(2'd0, got); check(12, got, 32'd0, "mode after reset");
    reg_read(2'd3, got); check(12, got, 32'd0, "result after reset");
    arr_peek(7'd0, got); check(12, got, 32'hFFFF_FFFF, "array after reset");
    reg_write(2'd1, cw(0, 8'h0A)); repeat (BUSY + 2) @(negedge clk);
    reg_read(2'd3, got); check(12, got, 32'd0, "locks after reset");

    for (int n = 0; n < N_VEC; n++) begin
      vec_t v;
      v = TBL[n];
      case (v.k)
        K_W: reg_write(v.a[1:0], v.d);
        K_R: begin reg_read(v.a[1:0], got); check(int'(v.r), got, v.e, $sformatf("row %0d reg read", n)); end
        K_B: buf_write(v.a[1:0], v.d);
        K_A: begin arr_peek(v.a[6:0], got); check(int'(v.r), got, v.e, $sformatf("row %0d array word", n)); end
        default: repeat (BUSY + 2) @(negedge clk);
      endcase
    end

    // R3 exact busy window
    reg_write(2'd1, cw(3, 8'h03));
    low = 0;
    for (int c = 0; c < 50; c++) begin
      reg_peek(2'd2, got);
      if (got[0]) break;
      low++;
    end
    check(3, 32'(low), 32'(BUSY), "ready-low cycles");

    // R4 command during busy is dropped and flagged
    reg_write(2'd1, cw(0, 8'h03));
    reg_write(2'd1, cw(0, 8'h08));
    repeat (BUSY + 2) @(negedge clk);
    reg_read(2'd2, got); check(4, got, 32'd3, "status after busy write");
    reg_write(2'd1, cw(0, 8'h0A)); repeat (BUSY + 2) @(negedge clk);
    reg_read(2'd3, got); check(4, got, 32'h80, "region 0 untouched");

    finish_run();
  end
endmodule